// File: doc/BRIEF.md
# Dual Down-Counting System Timer

This peripheral holds two independent 32-bit down-counters that run from one fabric clock. Software programs them through a plain register bus with an address, a write strobe, write data and combinational read data. A single control word holds the settings for both timers: run, auto-reload, tick source and a prescaler exponent. Each timer also has a reload register and a live count register. A status word holds one sticky event flag per timer. Each flag also drives a level interrupt output.

A timer decrements once per count tick. The tick comes either from a power-of-two division of the fabric clock or from a pulse on the shared reference tick input. When a tick arrives while the count is zero, the timer expires. In auto-reload mode the count takes the reload value and the timer keeps running. In one-shot mode the count stays at zero and the timer fires no further event until software writes its count again. If software loads all-ones into both registers of a timer and enables auto-reload, the timer becomes a free-running wrapping counter.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The control word at 0x00 stores only these bits: 0 (timer 0 run), 1 (timer 0 auto-reload), 2 (timer 1 run), 3 (timer 1 auto-reload), 11 (timer 0 reference tick), 12 (timer 1 reference tick), 21:19 (timer 0 exponent) and 24:22 (timer 1 exponent). All other bits read 0.
- R3: A running timer that uses the fabric clock with exponent n decrements by one every 2^n cycles. Its prescaler is held at zero while the timer is stopped, so the first decrement comes 2^n cycles after the timer is enabled.
- R4: A timer whose reference-tick bit is set decrements once for each fabric cycle in which ref_tick_i is high, and its exponent has no effect.
- R5: A stopped timer holds its count.
- R6: A write to a count register (timer 0 at 0x14, timer 1 at 0x1C) loads the count on that edge and takes priority over a decrement. A read of that register returns the live count.
- R7: In auto-reload mode, a tick at count 0 loads the reload register (timer 0 at 0x10, timer 1 at 0x18) and sets the timer's event flag.
- R8: In one-shot mode, a tick at count 0 sets the event flag once. The count then stays at 0 and the run bit stays set. No further event occurs until the count register is written again.
- R9: Status word 0x04 holds the timer 0 flag in bit 0 and the timer 1 flag in bit 8. Writing a 0 to a flag bit clears that flag, and writing a 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R10: irq0_o and irq1_o are high exactly while their event flags are set.
- R11: With reload and count both at 0xFFFFFFFF and auto-reload enabled, the timer counts down through zero, wraps to 0xFFFFFFFF and raises its flag on the wrap.
- R12: The two timers are independent. Each one uses only its own control fields and counts at its own rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW (5) | Byte address of the register |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for addr_i, combinational |
| ref_tick_i | input | 1 | Reference tick pulse, one fabric cycle wide |
| irq0_o | output | 1 | Timer 0 event interrupt, level |
| irq1_o | output | 1 | Timer 1 event interrupt, level |

## Verification
On every cycle the assertions check the following. A count moves by at most one step unless it is written. A written count takes the written value. A stopped timer holds its count. A one-shot timer stays at zero. A flag stays set until a write clears it, and a flag rises only when its count was zero. The bench scenarios cover what needs a known program of register writes: the exact prescaler period after enable, the reference-tick rate, the reload value taken at expiry, the free-running wrap, the control readback mask, and expiry winning over a simultaneous clear.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NTMR = 2;

  localparam logic [7:0] CTRL_OFF = 8'h00;
  localparam logic [7:0] STAT_OFF = 8'h04;
  localparam logic [7:0] RLD_OFF [NTMR] = '{8'h10, 8'h18};
  localparam logic [7:0] VAL_OFF [NTMR] = '{8'h14, 8'h1C};

  localparam int EN_POS   [NTMR] = '{0, 2};
  localparam int AR_POS   [NTMR] = '{1, 3};
  localparam int REF_POS  [NTMR] = '{11, 12};
  localparam int DIV_LSB  [NTMR] = '{19, 22};
  localparam int FLAG_POS [NTMR] = '{0, 8};

  function automatic logic [31:0] ctrl_mask(input int div_w);
    logic [31:0] m;
    m = '0;
    for (int t = 0; t < NTMR; t++) begin
      m[EN_POS[t]]  = 1'b1;
      m[AR_POS[t]]  = 1'b1;
      m[REF_POS[t]] = 1'b1;
      for (int b = 0; b < div_w; b++) m[DIV_LSB[t] + b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ref_sel_i,
  input  logic             ref_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  // low n bits all ones -> one pulse every 2^n cycles
  assign mask   = ~({PS_W{1'b1}} << div_i);
  assign tick_o = en_i & (ref_sel_i ? ref_tick_i : ((cnt_q & mask) == mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          auto_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] reload_i,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q;
  logic          done_q;
  logic          at_zero;

  assign at_zero  = (cnt_q == '0);
  assign count_o  = cnt_q;
  assign expire_o = tick_i & at_zero & (auto_i | ~done_q) & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      done_q <= 1'b0;
    end else if (tick_i) begin
      if (at_zero) begin
        if (auto_i) cnt_q  <= reload_i;
        else        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int DIV_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ref_tick_i,
  output logic          irq0_o,
  output logic          irq1_o
);
  localparam logic [DW-1:0] CMASK = DW'(ctrl_mask(DIV_W));

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] reload_q [NTMR];
  logic [DW-1:0] cnt_w    [NTMR];
  logic [NTMR-1:0] flag_q, exp_w, wr_val, wr_rld;
  logic wr_ctrl, wr_stat;

  assign wr_ctrl = we_i && (addr_i == CTRL_OFF[AW-1:0]);
  assign wr_stat = we_i && (addr_i == STAT_OFF[AW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata_i & CMASK;
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic tick;

    assign wr_val[t] = we_i && (addr_i == VAL_OFF[t][AW-1:0]);
    assign wr_rld[t] = we_i && (addr_i == RLD_OFF[t][AW-1:0]);

    dtmr_prescaler #(.DIV_W(DIV_W)) u_ps (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ctrl_q[EN_POS[t]]),
      .ref_sel_i  (ctrl_q[REF_POS[t]]),
      .ref_tick_i (ref_tick_i),
      .div_i      (ctrl_q[DIV_LSB[t] +: DIV_W]),
      .tick_o     (tick)
    );

    dtmr_counter #(.DW(DW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .auto_i     (ctrl_q[AR_POS[t]]),
      .load_i     (wr_val[t]),
      .load_val_i (wdata_i),
      .reload_i   (reload_q[t]),
      .count_o    (cnt_w[t]),
      .expire_o   (exp_w[t])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        reload_q[t] <= '0;
      else if (wr_rld[t]) reload_q[t] <= wdata_i;
    end

    // expiry wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[t] <= 1'b0;
      else flag_q[t] <= exp_w[t] | (flag_q[t] & ~(wr_stat & ~wdata_i[FLAG_POS[t]]));
    end
  end

  assign irq0_o = flag_q[0];
  assign irq1_o = flag_q[1];

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFF[AW-1:0]) rdata_o = ctrl_q;
    if (addr_i == STAT_OFF[AW-1:0]) begin
      for (int t = 0; t < NTMR; t++) rdata_o[FLAG_POS[t]] = flag_q[t];
    end
    for (int t = 0; t < NTMR; t++) begin
      if (addr_i == RLD_OFF[t][AW-1:0]) rdata_o = reload_q[t];
      if (addr_i == VAL_OFF[t][AW-1:0]) rdata_o = cnt_w[t];
    end
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          irq0_o,
  input logic          irq1_o,
  input logic [DW-1:0] cnt0_i,
  input logic [DW-1:0] cnt1_i,
  input logic [DW-1:0] ctrl_i
);
  logic wr0, wr1, clr0, clr1;
  assign wr0  = we_i && (addr_i == AW'(8'h14));
  assign wr1  = we_i && (addr_i == AW'(8'h1C));
  assign clr0 = we_i && (addr_i == AW'(8'h04)) && !wdata_i[0];
  assign clr1 = we_i && (addr_i == AW'(8'h04)) && !wdata_i[8];

  a_r6_load0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> cnt0_i == $past(wdata_i));
  a_r6_load1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1 |=> cnt1_i == $past(wdata_i));
  a_r3_step0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr0 && cnt0_i != '0) |=> (cnt0_i == $past(cnt0_i) || cnt0_i == $past(cnt0_i) - 1'b1));
  a_r3_step1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr1 && cnt1_i != '0) |=> (cnt1_i == $past(cnt1_i) || cnt1_i == $past(cnt1_i) - 1'b1));
  a_r5_hold0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !wr0) |=> $stable(cnt0_i));
  a_r5_hold1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[2] && !wr1) |=> $stable(cnt1_i));
  a_r8_oneshot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[1] && cnt0_i == '0 && !wr0) |=> cnt0_i == '0);
  a_r8_oneshot1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[3] && cnt1_i == '0 && !wr1) |=> cnt1_i == '0);
  a_r9_sticky0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o && !clr0) |=> irq0_o);
  a_r9_sticky1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq1_o && !clr1) |=> irq1_o);
  a_r7_rise0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq0_o) |-> $past(cnt0_i) == '0);
  a_r7_rise1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq1_o) |-> $past(cnt1_i) == '0);
endmodule

bind dual_down_timer dtmr_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq0_o  (irq0_o),
  .irq1_o  (irq1_o),
  .cnt0_i  (cnt_w[0]),
  .cnt1_i  (cnt_w[1]),
  .ctrl_i  (ctrl_q)
);

// File: tb/dual_down_timer_tb.sv
module dual_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b0;
  logic        irq0, irq1;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04,
                         A_RLD0 = 5'h10, A_VAL0 = 5'h14,
                         A_RLD1 = 5'h18, A_VAL1 = 5'h1C;

  always #5 clk = ~clk;

  dual_down_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ref_tick_i(ref_tick), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 stat", A_STAT, 0);
    rd_chk("R1 val0", A_VAL0, 0);
    rd_chk("R1 rld1", A_RLD1, 0);
    chk("R1 irq", {30'd0, irq1, irq0}, 0);
  endtask

  task automatic t_ctrl_mask;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R2 mask", A_CTRL, 32'h01F8_180F);
    wr(A_CTRL, 0);
    wr(A_VAL0, 0); wr(A_VAL1, 0); wr(A_STAT, 0);
    rd_chk("R2 clear", A_CTRL, 0);
  endtask

  task automatic t_prescale;
    wr(A_VAL0, 10);
    wr(A_CTRL, 32'h1 | (32'd2 << 19));
    idle(3); rd_chk("R3 before first tick", A_VAL0, 10);
    idle(1); rd_chk("R3 first tick", A_VAL0, 9);
    idle(8); rd_chk("R3 period 4", A_VAL0, 7);
    wr(A_CTRL, 0);
    idle(10); rd_chk("R5 hold when stopped", A_VAL0, 7);
  endtask

  task automatic t_load_prio;
    wr(A_VAL0, 50);
    wr(A_CTRL, 32'h1);
    rd_chk("R6 loaded", A_VAL0, 50);
    idle(2); rd_chk("R6 live count", A_VAL0, 48);
    wr(A_VAL0, 100);
    rd_chk("R6 write beats decrement", A_VAL0, 100);
    idle(1); rd_chk("R6 continues", A_VAL0, 99);
    wr(A_CTRL, 0);
  endtask

  task automatic t_oneshot;
    wr(A_VAL0, 2); wr(A_STAT, 0);
    wr(A_CTRL, 32'h1);
    idle(2); rd_chk("R8 at zero", A_VAL0, 0);
    chk("R8 no flag yet", {31'd0, irq0}, 0);
    idle(1); chk("R8 flag on expiry", {31'd0, irq0}, 1);
    rd_chk("R8 holds zero", A_VAL0, 0);
    rd_chk("R8 run bit stays", A_CTRL, 32'h1);
    wr(A_STAT, 0);
    idle(5); chk("R8 no second event", {31'd0, irq0}, 0);
    rd_chk("R8 still zero", A_VAL0, 0);
    wr(A_VAL0, 0);
    idle(1); chk("R8 rearmed by write", {31'd0, irq0}, 1);
    wr(A_STAT, 32'hFFFF_FFFF);
    chk("R9 write one keeps flag", {31'd0, irq0}, 1);
    rd_chk("R9 status bit0", A_STAT, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFE);
    rd_chk("R9 write zero clears", A_STAT, 0);
    chk("R10 irq follows flag", {31'd0, irq0}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_autoreload;
    wr(A_RLD0, 3); wr(A_VAL0, 1); wr(A_STAT, 0);
    wr(A_CTRL, 32'h3);
    idle(1); rd_chk("R7 reach zero", A_VAL0, 0);
    idle(1); rd_chk("R7 reload", A_VAL0, 3);
    chk("R7 flag", {31'd0, irq0}, 1);
    idle(1); rd_chk("R7 keeps running", A_VAL0, 2);
    wr(A_CTRL, 0);
    // expiry every cycle: a clear write must lose
    wr(A_RLD0, 0); wr(A_VAL0, 0);
    wr(A_CTRL, 32'h3);
    idle(2);
    wr(A_STAT, 0);
    chk("R9 expiry beats clear", {31'd0, irq0}, 1);
    wr(A_CTRL, 0); wr(A_STAT, 0);
  endtask

  task automatic t_wrap;
    wr(A_RLD0, 32'hFFFF_FFFF); wr(A_VAL0, 0); wr(A_STAT, 0);
    wr(A_CTRL, 32'h3);
    idle(1); rd_chk("R11 wrap", A_VAL0, 32'hFFFF_FFFF);
    chk("R11 flag on wrap", {31'd0, irq0}, 1);
    idle(1); rd_chk("R11 continues", A_VAL0, 32'hFFFF_FFFE);
    wr(A_CTRL, 0); wr(A_STAT, 0);
  endtask

  task automatic t_ref_tick;
    wr(A_VAL1, 20);
    wr(A_CTRL, 32'h4 | 32'h1000 | (32'd7 << 22));
    idle(5); rd_chk("R4 no ref pulse", A_VAL1, 20);
    for (int i = 0; i < 4; i++) begin
      ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0; @(negedge clk);
    end
    rd_chk("R4 one per pulse", A_VAL1, 16);
    wr(A_CTRL, 0);
  endtask

  task automatic t_indep;
    wr(A_VAL0, 40); wr(A_VAL1, 40); wr(A_STAT, 0);
    wr(A_CTRL, 32'h5 | (32'd1 << 22));
    idle(8);
    rd_chk("R12 timer0 rate", A_VAL0, 32);
    rd_chk("R12 timer1 rate", A_VAL1, 36);
    wr(A_CTRL, 0);
    wr(A_VAL1, 0);
    wr(A_CTRL, 32'h4);
    idle(1);
    chk("R10 irq1", {30'd0, irq1, irq0}, 2'b10);
    rd_chk("R9 status bit8", A_STAT, 32'h100);
    wr(A_CTRL, 0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_ctrl_mask();
    t_prescale();
    t_load_prio();
    t_oneshot();
    t_autoreload();
    t_wrap();
    t_ref_tick();
    t_indep();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule